// File: doc/BRIEF.md
# Inbound Doorbell Queue

This block receives inbound doorbell events and keeps them in a local circular ring of fixed-size slots until the host consumes them. Each event carries a source ID, a target ID and a 16-bit info value. The block packs them into a 64-bit slot at the enqueue position. The host sees the slot at the dequeue position through a read port, together with the byte offsets of both pointers. After it has processed the slot, the host writes the mode register with the advance bit set, and the dequeue pointer moves to the next slot.

Three sticky status flags report the queue state: entries present, queue full and transaction error. The host clears each flag by writing 1 to its position. The interrupt line is raised while any status flag whose enable bit in the mode register is set is itself set. The ring depth and the ID width are parameters. The default is 512 slots of 8 bytes, which is 4 KB, so each pointer offset is 12 bits wide.

Top module: `dbq_unit`

## Requirements
- R1: After reset the enqueue and dequeue offsets are 0, and status, mode and irq are all 0.
- R2: An accepted doorbell is stored as the 64-bit word {16'h0, target, source, info}. Target occupies bits 47:32, source bits 31:16 and info bits 15:0, with each ID zero-extended to 16 bits. head_entry shows the slot at the dequeue pointer.
- R3: Each pointer offset equals its slot index times 8 and wraps to 0 after DEPTH slots.
- R4: Mode bit 0 enables the unit. While it is 0, incoming doorbells and error pulses change neither the pointers nor the status.
- R5: A mode write with bit 1 set advances the dequeue pointer by one slot when the ring is not empty. Bit 1 always reads back as 0, and only mode bits 0, 5, 6 and 7 are kept.
- R6: An advance command given while the ring is empty leaves the dequeue pointer unchanged.
- R7: Status bit 0 is set whenever the ring holds entries. A write of 1 clears it. If entries remain, it is set again one cycle later; if the ring is empty, it stays clear.
- R8: Status bit 4 is set when an accepted doorbell fills the last free slot, or when a doorbell arrives while the ring is full. Such a doorbell is dropped and the stored entries are kept. Fullness is judged before any advance in the same cycle.
- R9: Status bit 7 is set by an error pulse while the unit is enabled. For bits 4 and 7, a new event wins over a clear in the same cycle. Writing 0 to a status bit leaves it unchanged.
- R10: irq is high while status bit 0 and mode bit 5 are both set, or status bit 4 and mode bit 6, or status bit 7 and mode bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| db_valid | input | 1 | Inbound doorbell present this cycle |
| db_src | input | ID_W | Source ID of the doorbell |
| db_tgt | input | ID_W | Target ID of the doorbell |
| db_info | input | 16 | Info value of the doorbell |
| db_err | input | 1 | Transaction error pulse |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode write data (bit 1 is the advance command) |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 8 | Status bits to clear |
| mode_rd | output | 8 | Mode register contents |
| status_rd | output | 8 | Status register contents |
| deq_off | output | OFF_W | Byte offset of the dequeue pointer |
| enq_off | output | OFF_W | Byte offset of the enqueue pointer |
| head_entry | output | 64 | Slot at the dequeue pointer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the following behaviours: the enqueue pointer holds while the ring is full or the unit is disabled, an advance on an empty ring does nothing, occupancy rises by exactly one on a plain accept, and the entries-present and error flags set after their triggering conditions. Only the bench scenarios can show the slot packing, the wrap of the offsets, and the drop decision when an arrival and an advance happen in the same cycle on a full ring. The same holds for the priority between a clear and a new event and for the mapping of each interrupt enable bit. The bench fills, overflows and drains a small ring and compares every slot against values it computes itself.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
   localparam int ST_NE   = 0;
   localparam int ST_FULL = 4;
   localparam int ST_ERR  = 7;

   localparam int MD_EN      = 0;
   localparam int MD_ADV     = 1;
   localparam int MD_IE_NE   = 5;
   localparam int MD_IE_FULL = 6;
   localparam int MD_IE_ERR  = 7;

   localparam logic [7:0] MODE_KEEP = 8'hE1;
   localparam logic [7:0] STS_KEEP  = 8'h91;

   typedef struct packed {
      logic [15:0] pad;
      logic [15:0] tgt;
      logic [15:0] src;
      logic [15:0] info;
   } dbq_slot_t;
endpackage

// File: rtl/dbq_ring.sv
module dbq_ring
   import dbq_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int ID_W  = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [ID_W-1:0]  wr_src,
   input  logic [ID_W-1:0]  wr_tgt,
   input  logic [15:0]      wr_info,
   input  logic             rd_req,
   output logic             empty,
   output logic             full,
   output logic             last_free,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output dbq_slot_t        head
);
   logic [CNT_W-1:0] wr_ptr, rd_ptr, count;
   logic [15:0]      src16, tgt16;
   logic             wr_ok, rd_ok;
   dbq_slot_t        mem [DEPTH];

   generate
      if (ID_W == 16) begin : g_id_full
         assign src16 = wr_src;
         assign tgt16 = wr_tgt;
      end else begin : g_id_ext
         assign src16 = {{(16-ID_W){1'b0}}, wr_src};
         assign tgt16 = {{(16-ID_W){1'b0}}, wr_tgt};
      end
   endgenerate

   assign count     = wr_ptr - rd_ptr;
   assign empty     = (count == '0);
   assign full      = (count == CNT_W'(DEPTH));
   assign last_free = (count == CNT_W'(DEPTH - 1));
   assign wr_ok     = wr_req && !full;
   assign rd_ok     = rd_req && !empty;
   assign wr_idx    = wr_ptr[IDX_W-1:0];
   assign rd_idx    = rd_ptr[IDX_W-1:0];
   assign head      = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_idx] <= '{pad: 16'h0, tgt: tgt16, src: src16, info: wr_info};
   end

   // R8
   drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_req) |=> $stable(wr_ptr));
   // R6
   empty_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_req) |=> $stable(rd_ptr));
   // R3
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !full && !rd_ok) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/dbq_status.sv
module dbq_status
   import dbq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       nonempty,
   input  logic       set_ne,
   input  logic       set_full,
   input  logic       set_err,
   input  logic       clr_we,
   input  logic [7:0] clr_data,
   input  logic [2:0] ie,
   output logic [7:0] sts_q,
   output logic       irq
);
   logic [7:0] clr_v, set_v, sts_n;

   always_comb begin
      clr_v          = clr_we ? clr_data : 8'h00;
      set_v          = 8'h00;
      set_v[ST_FULL] = set_full;
      set_v[ST_ERR]  = set_err;
      sts_n          = ((sts_q & ~clr_v) | set_v) & STS_KEEP;
      sts_n[ST_NE]   = clr_v[ST_NE] ? 1'b0 : (sts_q[ST_NE] | set_ne | nonempty);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= 8'h00;
      else        sts_q <= sts_n;
   end

   assign irq = (sts_q[ST_NE] & ie[0]) | (sts_q[ST_FULL] & ie[1]) | (sts_q[ST_ERR] & ie[2]);

   // R7
   ne_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nonempty && !(clr_we && clr_data[ST_NE])) |=> sts_q[ST_NE]);
   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_err |=> sts_q[ST_ERR]);
endmodule

// File: rtl/dbq_unit.sv
module dbq_unit
   import dbq_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int ID_W  = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int OFF_W = IDX_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             db_valid,
   input  logic [ID_W-1:0]  db_src,
   input  logic [ID_W-1:0]  db_tgt,
   input  logic [15:0]      db_info,
   input  logic             db_err,
   input  logic             mode_we,
   input  logic [7:0]       mode_wdata,
   input  logic             sts_we,
   input  logic [7:0]       sts_wdata,
   output logic [7:0]       mode_rd,
   output logic [7:0]       status_rd,
   output logic [OFF_W-1:0] deq_off,
   output logic [OFF_W-1:0] enq_off,
   output logic [63:0]      head_entry,
   output logic             irq
);
   initial begin : param_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (ID_W >= 1 && ID_W <= 16)
         else $error("ID_W must lie between 1 and 16");
   end

   logic [7:0]       mode_q;
   logic             en, wr_req, adv, empty, full, last_free;
   logic             set_full, set_err;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   dbq_slot_t        head;

   assign en       = mode_q[MD_EN];
   assign wr_req   = db_valid && en;
   assign adv      = mode_we && mode_wdata[MD_ADV];
   assign set_full = wr_req && (full || (last_free && !(adv && !empty)));
   assign set_err  = db_err && en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= 8'h00;
      else if (mode_we) mode_q <= mode_wdata & MODE_KEEP;
   end

   dbq_ring #(.DEPTH(DEPTH), .ID_W(ID_W)) i_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .wr_src    (db_src),
      .wr_tgt    (db_tgt),
      .wr_info   (db_info),
      .rd_req    (adv),
      .empty     (empty),
      .full      (full),
      .last_free (last_free),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .head      (head)
   );

   dbq_status i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .nonempty (!empty),
      .set_ne   (wr_req && !full),
      .set_full (set_full),
      .set_err  (set_err),
      .clr_we   (sts_we),
      .clr_data (sts_wdata),
      .ie       ({mode_q[MD_IE_ERR], mode_q[MD_IE_FULL], mode_q[MD_IE_NE]}),
      .sts_q    (status_rd),
      .irq      (irq)
   );

   assign mode_rd    = mode_q;
   assign deq_off    = {rd_idx, 3'b000};
   assign enq_off    = {wr_idx, 3'b000};
   assign head_entry = head;

   // R4
   disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (db_valid && !en) |=> $stable(enq_off));
   // R5
   adv_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> !mode_rd[MD_ADV]);
endmodule

// File: tb/test_dbq_unit.sv
`timescale 1ns/1ps
module test_dbq_unit;
   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        db_valid = 1'b0, db_err = 1'b0, mode_we = 1'b0, sts_we = 1'b0;
   logic [7:0]  db_src = '0, db_tgt = '0, mode_wdata = '0, sts_wdata = '0;
   logic [15:0] db_info = '0;
   logic [7:0]  mode_rd, status_rd;
   logic [5:0]  deq_off, enq_off;
   logic [63:0] head_entry;
   logic        irq;

   int checks = 0, errors = 0;
   int wr = 0, rd = 0;
   bit en_m = 0, done = 0;
   logic [63:0] q [D];

   always #2 clk = ~clk;

   dbq_unit #(.DEPTH(D), .ID_W(8)) i_dbq_unit (
      .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_src(db_src), .db_tgt(db_tgt),
      .db_info(db_info), .db_err(db_err), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .sts_we(sts_we), .sts_wdata(sts_wdata), .mode_rd(mode_rd), .status_rd(status_rd),
      .deq_off(deq_off), .enq_off(enq_off), .head_entry(head_entry), .irq(irq));

   function automatic logic [63:0] mk(input logic [7:0] s, input logic [7:0] t, input logic [15:0] i);
      return {16'h0, 8'h0, t, 8'h0, s, i};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] s, input logic [7:0] t, input logic [15:0] i);
      db_valid = 1'b1; db_src = s; db_tgt = t; db_info = i;
      tick();
      db_valid = 1'b0;
      if (en_m && (wr - rd) < D) begin
         q[wr % D] = mk(s, t, i);
         wr++;
      end
   endtask

   task automatic mode_wr(input logic [7:0] v);
      mode_we = 1'b1; mode_wdata = v;
      tick();
      mode_we = 1'b0;
      en_m = v[0];
      if (v[1] && wr != rd) rd++;
   endtask

   task automatic sts_clr(input logic [7:0] v);
      sts_we = 1'b1; sts_wdata = v;
      tick();
      sts_we = 1'b0;
   endtask

   task automatic pulse_err();
      db_err = 1'b1;
      tick();
      db_err = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 enq_off", enq_off, 0);
      chk("R1 deq_off", deq_off, 0);
      chk("R1 status", status_rd, 0);
      chk("R1 mode", mode_rd, 0);
      chk("R1 irq", irq, 0);

      // R4 disabled unit ignores doorbells and errors
      send(8'h01, 8'h02, 16'h0003);
      chk("R4 enq_off", enq_off, 0);
      chk("R4 status", status_rd, 0);
      pulse_err();
      chk("R4 err", status_rd[7], 0);

      // R5 / R6 advance on empty ring
      mode_wr(8'h01);
      mode_wr(8'h03);
      chk("R6 deq_off", deq_off, 0);
      chk("R5 mode readback", mode_rd, 8'h01);
      mode_wr(8'h1F);
      chk("R5 kept bits", mode_rd, 8'h01);

      // fill sweep
      for (int k = 0; k < D; k++) begin
         send(8'(k * 17 + 3), 8'(8'hF0 - k), 16'(16'h1111 * k) ^ 16'h00A5);
         chk("R3 enq_off", enq_off, ((k + 1) * 8) % (D * 8));
         chk("R7 ne set", status_rd[0], 1);
         chk("R8 full flag", status_rd[4], (k == D - 1));
      end
      chk("R2 head", head_entry, q[0]);

      // R8 overflow drop
      send(8'hEE, 8'hEE, 16'hBEEF);
      chk("R8 enq kept", enq_off, 0);
      chk("R8 head kept", head_entry, q[0]);
      sts_clr(8'h10);
      chk("R8 full cleared", status_rd[4], 0);
      send(8'hEE, 8'hEE, 16'hBEEF);
      chk("R8 full reset", status_rd[4], 1);

      // R8 arrival and advance in the same cycle on a full ring
      db_valid = 1'b1; db_src = 8'h55; db_tgt = 8'h66; db_info = 16'h7777;
      mode_we = 1'b1; mode_wdata = 8'h03;
      tick();
      db_valid = 1'b0; mode_we = 1'b0;
      rd++;
      chk("R8 same-cycle drop", enq_off, 0);
      chk("R5 advance", deq_off, 8);

      // drain
      while (rd < wr) begin
         chk("R2 drain head", head_entry, q[rd % D]);
         chk("R3 deq_off", deq_off, (rd % D) * 8);
         mode_wr(8'h03);
      end
      chk("R3 deq wrap", deq_off, 0);
      sts_clr(8'h01);
      chk("R7 cleared", status_rd[0], 0);
      tick();
      chk("R7 stays clear empty", status_rd[0], 0);

      // R7 rearm
      send(8'h05, 8'h06, 16'h0007);
      chk("R3 enq after wrap", enq_off, (wr % D) * 8);
      chk("R2 id ext", head_entry, 64'h0000_0006_0005_0007);
      sts_clr(8'h01);
      chk("R7 clear pulse", status_rd[0], 0);
      tick();
      chk("R7 rearm", status_rd[0], 1);

      // R10 / R9
      sts_clr(8'h10);
      chk("R10 masked", irq, 0);
      mode_wr(8'h21);
      chk("R10 ne ie", irq, 1);
      mode_wr(8'h01);
      chk("R10 ne off", irq, 0);
      pulse_err();
      chk("R9 err set", status_rd[7], 1);
      chk("R10 err masked", irq, 0);
      mode_wr(8'h81);
      chk("R10 err ie", irq, 1);
      sts_clr(8'h80);
      chk("R9 err clr", status_rd[7], 0);
      chk("R10 err gone", irq, 0);
      db_err = 1'b1; sts_we = 1'b1; sts_wdata = 8'h80;
      tick();
      db_err = 1'b0; sts_we = 1'b0;
      chk("R9 set wins", status_rd[7], 1);
      sts_clr(8'h00);
      chk("R9 zero write", status_rd, 8'h81);

      mode_wr(8'h41);
      chk("R10 full masked", irq, 0);
      while ((wr - rd) < D) send(8'(wr), 8'(rd), 16'(wr * 3));
      chk("R8 full again", status_rd[4], 1);
      chk("R10 full ie", irq, 1);
      chk("R2 head final", head_entry, q[rd % D]);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule